// File: doc/BRIEF.md
# H-Bridge Command and Fault-Latch Core

This block is the digital heart of a full H-bridge motor driver. Two command inputs set the output level of two half-bridge legs. Each leg drives one side of the load. A global invert select treats both commands as active-low, so toggling it reverses the commanded current direction. When both commands are equal, toggling it moves the bridge between freewheel-high and freewheel-low. The block converts each leg's wanted level into separate high-side and low-side switch commands. It inserts a programmable dead time on every change, so that both switches of a leg are off before either turns on.

Three inputs can force every switch off: two disables of opposite polarity and a sleep enable. Short-circuit and overtemperature indications arrive as synchronous flags. Either one turns all switches off at once and sets a latched fault, which an active-low status output reports. The latch is cleared only by an edge on one of the disables or on the enable, and only if no fault flag is present at that moment. A reset also clears it. Every asynchronous control input passes through a two-flop synchronizer.

Top module: `hbridge_ctrl_core`

## Requirements
- R1: With no blocking condition and `inv_sel`=0, `cmd_a`=1 gives leg A high-side on and low-side off (`leg_a_hs`=1, `leg_a_ls`=0), and `cmd_a`=0 gives the reverse. `cmd_b` controls leg B the same way, independently of leg A.
- R2: With `inv_sel`=1, each command is taken as active-low: a command of 0 turns the leg's high side on and a command of 1 turns its low side on.
- R3: While `dis_hi`=1, all four switch outputs are 0.
- R4: While `dis_lo_n`=0, all four switch outputs are 0.
- R5: While `wake`=0, all four switch outputs are 0.
- R6: A 1 on `short_flt` or `hot_flt` in a cycle makes all four switch outputs 0 after the next rising edge and drives `stat_n` to 0.
- R7: Once set, the fault latch stays set after both fault flags return to 0. It clears only on a synchronized edge of `dis_hi`, `dis_lo_n` or `wake` seen while neither fault flag is 1. An edge seen while a flag is still 1 leaves the latch set.
- R8: During and right after reset, all four switch outputs are 0 and `stat_n` is 1.
- R9: When a leg's command changes, its switches are both off for DEAD_CYC+1 cycles before the new switch turns on. A command input changed before a rising edge gives the old switch off after the third rising edge and the new switch on after the (DEAD_CYC+4)th rising edge.
- R10: The high-side and low-side outputs of one leg are never 1 in the same cycle.
- R11: With `cmd_a`=`cmd_b`, both legs drive the same side: both high sides on, or both low sides on. Toggling `inv_sel` swaps between these two states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_a | input | 1 | Level command for leg A (asynchronous) |
| cmd_b | input | 1 | Level command for leg B (asynchronous) |
| inv_sel | input | 1 | 1 = commands are active-low |
| dis_hi | input | 1 | Disable, active high |
| dis_lo_n | input | 1 | Disable, active low |
| wake | input | 1 | 0 = sleep, all switches off |
| short_flt | input | 1 | Synchronous short-circuit flag |
| hot_flt | input | 1 | Synchronous overtemperature flag |
| leg_a_hs | output | 1 | Leg A high-side switch on |
| leg_a_ls | output | 1 | Leg A low-side switch on |
| leg_b_hs | output | 1 | Leg B high-side switch on |
| leg_b_ls | output | 1 | Leg B low-side switch on |
| stat_n | output | 1 | Status, 0 while a fault is latched |

## Verification
The bench measures the exact edge on which a reversed leg turns its new switch on. A design that skipped or shortened the dead time would turn it on early, and a count off by one would show up on the wrong edge. It removes a fault flag and then checks that the status stays low, which catches a latch that is really just a pass-through. It toggles a disable while a fault flag is still present, which catches a design that clears on the edge alone. It also pairs equal commands with each invert setting, which catches a decode that inverts only one leg. A monitor samples every cycle to catch any overlap of high-side and low-side commands.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_cmd_e;

  // Wanted leg state from one command bit, the invert select and the block term
  function automatic leg_cmd_e leg_target(input logic cmd, input logic inv,
                                          input logic blocked);
    logic eff;
    eff = cmd ^ inv;
    if (blocked)  return LEG_OFF;
    else if (eff) return LEG_HI;
    else          return LEG_LO;
  endfunction

  // Any edge across a group of synchronized signals
  function automatic logic any_edge3(input logic [2:0] now_v,
                                     input logic [2:0] prev_v);
    return |(now_v ^ prev_v);
  endfunction

endpackage

// File: rtl/hb_sync2.sv
module hb_sync2 #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch
  import hb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clr_src_i,   // synchronized disable/enable group
  input  logic       short_i,
  input  logic       hot_i,
  output logic       latched_o,
  output logic       clr_evt_o
);
  logic [2:0] src_prev_q;
  logic       latch_q;
  logic       flt_now;
  logic       src_edge;

  assign flt_now   = short_i | hot_i;
  assign src_edge  = any_edge3(clr_src_i, src_prev_q);
  assign clr_evt_o = latch_q & src_edge & ~flt_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_prev_q <= '0;
      latch_q    <= 1'b0;
    end else begin
      src_prev_q <= clr_src_i;
      if (flt_now)        latch_q <= 1'b1;
      else if (clr_evt_o) latch_q <= 1'b0;
    end
  end

  assign latched_o = latch_q;

  // R6: a fault flag always sets the latch
  p_fault_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flt_now |=> latch_q);
  // R7: latch holds unless a qualified clearing edge occurs
  p_latch_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !clr_evt_o) |=> latch_q);
  // R7: latch never sets without a fault flag
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_q && !flt_now) |=> !latch_q);
endmodule

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_i,
  input  logic inv_i,
  input  logic block_i,
  output logic hs_o,
  output logic ls_o
);
  localparam int CNT_W = $clog2(DEAD_CYC + 1);

  leg_cmd_e   tgt;
  leg_cmd_e   last_q;
  leg_cmd_e   drv_q;
  logic [CNT_W-1:0] gap_q;
  logic       tgt_change;

  assign tgt        = leg_target(cmd_i, inv_i, block_i);
  assign tgt_change = (tgt != last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= LEG_OFF;
      drv_q  <= LEG_OFF;
      gap_q  <= '0;
    end else if (tgt_change) begin
      last_q <= tgt;
      drv_q  <= LEG_OFF;
      gap_q  <= CNT_W'(DEAD_CYC);
    end else if (gap_q != '0) begin
      gap_q  <= gap_q - 1'b1;
    end else begin
      drv_q  <= tgt;
    end
  end

  assign hs_o = (drv_q == LEG_HI);
  assign ls_o = (drv_q == LEG_LO);

  // R10: never both switches of one leg
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_o && ls_o));
  // R9: a switch turns on only after a cycle with both off
  p_hs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_o) |-> !$past(ls_o));
  p_ls_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_o) |-> !$past(hs_o));
  // R6: a block forces the leg off on the next edge
  p_block_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    block_i |=> (!hs_o && !ls_o));
endmodule

// File: rtl/hbridge_ctrl_core.sv
module hbridge_ctrl_core
  import hb_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_a,
  input  logic cmd_b,
  input  logic inv_sel,
  input  logic dis_hi,
  input  logic dis_lo_n,
  input  logic wake,
  input  logic short_flt,
  input  logic hot_flt,
  output logic leg_a_hs,
  output logic leg_a_ls,
  output logic leg_b_hs,
  output logic leg_b_ls,
  output logic stat_n
);
  localparam int NLEG  = 2;
  localparam int SYNCW = NLEG + 4;

  logic [SYNCW-1:0] raw_in;
  logic [SYNCW-1:0] syn_in;
  logic [NLEG-1:0]  cmd_s;
  logic             inv_s, dis_hi_s, dis_lo_s, wake_s;
  logic             fault_latched;
  logic             clr_evt;
  logic             bridge_block;
  logic [NLEG-1:0]  hs_v, ls_v;

  assign raw_in = {wake, dis_lo_n, dis_hi, inv_sel, cmd_b, cmd_a};

  hb_sync2 #(.W(SYNCW), .RST_VAL('0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn_in)
  );

  assign cmd_s    = syn_in[NLEG-1:0];
  assign inv_s    = syn_in[NLEG];
  assign dis_hi_s = syn_in[NLEG+1];
  assign dis_lo_s = syn_in[NLEG+2];
  assign wake_s   = syn_in[NLEG+3];

  hb_fault_latch u_flt (
    .clk(clk), .rst_n(rst_n),
    .clr_src_i({wake_s, dis_lo_s, dis_hi_s}),
    .short_i(short_flt), .hot_i(hot_flt),
    .latched_o(fault_latched), .clr_evt_o(clr_evt)
  );

  assign bridge_block = dis_hi_s | ~dis_lo_s | ~wake_s | fault_latched
                      | short_flt | hot_flt;

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk(clk), .rst_n(rst_n),
      .cmd_i(cmd_s[g]), .inv_i(inv_s), .block_i(bridge_block),
      .hs_o(hs_v[g]), .ls_o(ls_v[g])
    );
  end

  assign leg_a_hs = hs_v[0];
  assign leg_a_ls = ls_v[0];
  assign leg_b_hs = hs_v[1];
  assign leg_b_ls = ls_v[1];
  assign stat_n   = ~fault_latched;

  // R6: status low follows a fault flag on the next edge
  p_stat_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (short_flt || hot_flt) |=> !stat_n);
  // R7: a qualified clearing event releases the status on the next edge
  p_stat_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> stat_n);
  // R3 R4 R5: a synchronized disable or sleep leaves every switch off next edge
  p_disable_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_hi_s || !dis_lo_s || !wake_s) |=> ($countones({hs_v, ls_v}) == 0));
endmodule

// File: tb/hbridge_ctrl_core_tb_top.sv
`timescale 1ns/1ps
module hbridge_ctrl_core_tb_top;
  localparam int DEAD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_a = 0, cmd_b = 0, inv_sel = 0, dis_hi = 0, dis_lo_n = 1, wake = 1;
  logic short_flt = 0, hot_flt = 0;
  logic leg_a_hs, leg_a_ls, leg_b_hs, leg_b_ls, stat_n;

  int n_chk = 0;
  int n_err = 0;
  int overlap_seen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hbridge_ctrl_core #(.DEAD_CYC(DEAD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_a(cmd_a), .cmd_b(cmd_b), .inv_sel(inv_sel),
    .dis_hi(dis_hi), .dis_lo_n(dis_lo_n), .wake(wake),
    .short_flt(short_flt), .hot_flt(hot_flt),
    .leg_a_hs(leg_a_hs), .leg_a_ls(leg_a_ls), .leg_b_hs(leg_b_hs),
    .leg_b_ls(leg_b_ls), .stat_n(stat_n)
  );

  // vector: {cmd_a, cmd_b, inv, exp a_hs, a_ls, b_hs, b_ls}
  localparam logic [6:0] VEC [8] = '{
    7'b000_0101, 7'b100_1001, 7'b010_0110, 7'b110_1010,
    7'b001_1010, 7'b101_0110, 7'b011_1001, 7'b111_0101
  };

  function automatic logic [3:0] sw();
    return {leg_a_hs, leg_a_ls, leg_b_hs, leg_b_ls};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // R10: overlap monitor
  always @(negedge clk)
    if (rst_n && ((leg_a_hs && leg_a_ls) || (leg_b_hs && leg_b_ls))) overlap_seen++;

  task automatic finish_run();
    chk("R10 overlap count", overlap_seen, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    edges(3);
    chk("R8 switches in reset", sw(), 4'b0000);
    chk("R8 status in reset", stat_n, 1);
    rst_n = 1;
    edges(1);
    chk("R8 switches after reset", sw(), 4'b0000);
    chk("R8 status after reset", stat_n, 1);

    // R1 R2 R11 table
    for (int i = 0; i < 8; i++) begin
      {cmd_a, cmd_b, inv_sel} = VEC[i][6:4];
      edges(20);
      chk($sformatf("R1/R2/R11 vec %0d", i), sw(), VEC[i][3:0]);
    end

    // R11 freewheel swap via invert
    cmd_a = 1; cmd_b = 1; inv_sel = 0; edges(20);
    chk("R11 freewheel high", sw(), 4'b1010);
    inv_sel = 1; edges(20);
    chk("R11 freewheel low", sw(), 4'b0101);
    inv_sel = 0; cmd_a = 1; cmd_b = 0; edges(20);

    // R9 dead time latency on leg A: hi -> lo
    cmd_a = 0;
    edges(2);
    chk("R9 old switch still on after 2 edges", sw(), 4'b1001);
    edges(1);
    chk("R9 leg off after 3 edges", sw(), 4'b0001);
    edges(DEAD - 1);
    chk("R9 still off after DEAD+2 edges", sw(), 4'b0001);
    edges(1);
    chk("R9 still off after DEAD+3 edges", sw(), 4'b0001);
    edges(1);
    chk("R9 new switch on after DEAD+4 edges", sw(), 4'b0101);
    cmd_a = 1; edges(20);

    // R3 R4 R5
    dis_hi = 1; edges(6);
    chk("R3 disable high", sw(), 4'b0000);
    chk("R3 no fault", stat_n, 1);
    dis_hi = 0; edges(20);
    chk("R3 recovery", sw(), 4'b1001);
    dis_lo_n = 0; edges(6);
    chk("R4 disable low", sw(), 4'b0000);
    dis_lo_n = 1; edges(20);
    chk("R4 recovery", sw(), 4'b1001);
    wake = 0; edges(6);
    chk("R5 sleep", sw(), 4'b0000);
    wake = 1; edges(20);
    chk("R5 recovery", sw(), 4'b1001);

    // R6 short fault
    short_flt = 1; edges(1);
    chk("R6 off after one edge", sw(), 4'b0000);
    chk("R6 status low", stat_n, 0);
    short_flt = 0; edges(20);
    chk("R7 latch persists", stat_n, 0);
    chk("R7 switches stay off", sw(), 4'b0000);
    // R7 toggle while fault present: no clear
    short_flt = 1;
    dis_hi = 1; edges(6); dis_hi = 0; edges(6);
    chk("R7 no clear with fault present", stat_n, 0);
    short_flt = 0; edges(6);
    chk("R7 still latched", stat_n, 0);
    // R7 clear by toggling dis_hi
    dis_hi = 1; edges(6);
    chk("R7 cleared by disable edge", stat_n, 1);
    dis_hi = 0; edges(20);
    chk("R7 drive resumes", sw(), 4'b1001);

    // R6 overtemp, clear via wake toggle
    hot_flt = 1; edges(1);
    chk("R6 overtemp off", sw(), 4'b0000);
    hot_flt = 0; edges(10);
    chk("R7 overtemp latched", stat_n, 0);
    wake = 0; edges(6);
    chk("R7 cleared by wake edge", stat_n, 1);
    wake = 1; edges(20);
    chk("R5 resume after wake", sw(), 4'b1001);

    // R7 clear via dis_lo_n
    hot_flt = 1; edges(1); hot_flt = 0; edges(10);
    dis_lo_n = 0; edges(6);
    chk("R7 cleared by low disable edge", stat_n, 1);
    dis_lo_n = 1; edges(20);
    chk("R4 resume", sw(), 4'b1001);

    done = 1;
    finish_run();
  end
endmodule